// File: doc/BRIEF.md
# Signed Array Multiplier (Two's-Complement, Sign-Corrected Partial Products)

This block multiplies two signed two's-complement operands and returns their exact double-width product. In a receive chain it serves as the mixer. One operand is a digitised sample and the other is a sine or cosine value from a numerically controlled oscillator. One copy of the block is placed on each quadrature arm.

The product comes from an explicit partial-product array, not from a behavioural multiply. The sign-related partial-product bits are inverted, and two fixed correction ones are added, so no partial product needs sign extension. The rows are then accumulated through a chain of ripple-carry adders built from full-adder cells. A parameter chooses whether the result leaves through one output register or straight from the adder chain.

Top module: `bw_mult`

## Requirements
- R1: Both operands are 16-bit two's-complement values, and the 32-bit output equals their exact two's-complement product for every operand pair.
- R2: The most negative value times itself (-32768 × -32768) gives 0x40000000 (2^30).
- R3: -32768 × 32767 gives 0xC0008000 (-1073709056), and this holds in either operand order.
- R4: When either operand is zero, the product is zero.
- R5: When both operands are nonzero, output bit 31 equals the XOR of the two operand sign bits (bit 15 of each).
- R6: With OUT_REG = 1 (the default), the product of the operands sampled at a rising clock edge appears on the output after that edge and stays there until the next edge.
- R7: With OUT_REG = 1, the output register is cleared to zero at any rising edge where rst_n is low, whatever the operands are.
- R8: With OUT_REG = 0, the output follows the operands combinationally within the same cycle and does not depend on the clock or on reset.
- R9: The array inverts every partial-product bit op_a[j]·op_b[i] in which exactly one of i, j is 15. It keeps op_a[15]·op_b[15] as it is, adds a one at bit 16 and at bit 31, and discards the carry out of bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_a | input | 16 | Signed multiplicand (two's complement) |
| op_b | input | 16 | Signed multiplier (two's complement) |
| prod | output | 32 | Signed product (two's complement) |

## Verification
A fixed table covers all four sign combinations, small magnitudes, ±1 and single-bit powers of two. These patterns separate errors in the plain array bits from errors in the inverted sign row and column. The extremes -32768 and 32767 are paired with each other and with themselves. These pairs check the correction ones at bits 16 and 31, and they catch any leak of the discarded top carry. A long pseudo-random sweep exercises carry propagation across the whole ripple chain. A registered instance and a combinational instance run side by side, which shows the one-cycle latency and the reset clear against same-cycle output.

// File: rtl/bw_pkg.sv
// Package: shared widths and helper for the sign-corrected multiplier.
// Assumes operand width >= 2.
package bw_pkg;
    localparam int unsigned BW_OP_W = 16;

    // Correction constant: one at bit W and one at bit 2W-1.
    function automatic logic [2*BW_OP_W-1:0] bw_corr(input int unsigned w);
        logic [2*BW_OP_W-1:0] c;
        c = '0;
        c[w]       = 1'b1;
        c[2*w - 1] = 1'b1;
        return c;
    endfunction
endpackage

// File: rtl/bw_pp_array.sv
// Module: builds W shifted partial-product rows plus one correction row.
// Bits with exactly one sign index are inverted; the sign x sign bit is kept.
// Assumes W == bw_pkg::BW_OP_W so the correction row lines up.
module bw_pp_array #(
    parameter int unsigned W = bw_pkg::BW_OP_W
) (
    input  logic [W-1:0]            a,
    input  logic [W-1:0]            b,
    output logic [W:0][2*W-1:0]     rows
);
    localparam int unsigned PW = 2 * W;

    // Form each row: row i holds a[j]&b[i] at weight i+j, sign terms inverted.
    always_comb begin
        rows = '0;
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                if ((i == W - 1) != (j == W - 1))
                    rows[i][i + j] = ~(a[j] & b[i]);
                else
                    rows[i][i + j] = a[j] & b[i];
            end
        end
        rows[W] = PW'(bw_pkg::bw_corr(W));
    end
endmodule

// File: rtl/bw_rca.sv
// Module: N-bit ripple-carry adder made of full-adder cells.
// The carry out of the top bit is discarded (modulo 2^N sum).
module bw_rca #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] s
);
    logic [N-1:0] c;

    assign c[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_fa
        // Sum bit of one full-adder cell.
        assign s[k] = x[k] ^ y[k] ^ c[k];
        if (k < N - 1) begin : g_carry
            // Carry into the next cell.
            assign c[k + 1] = (x[k] & y[k]) | (x[k] & c[k]) | (y[k] & c[k]);
        end
    end
endmodule

// File: rtl/bw_mult.sv
// Module: top of the signed W x W multiplier. Partial-product rows are
// accumulated through a chain of ripple adders; the result is either
// registered (OUT_REG = 1, one cycle latency) or passed through (OUT_REG = 0).
// Assumes synchronous active-low reset; no multiply operator in the datapath.
module bw_mult #(
    parameter int unsigned W       = bw_pkg::BW_OP_W,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       op_a,
    input  logic [W-1:0]       op_b,
    output logic [2*W-1:0]     prod
);
    localparam int unsigned PW    = 2 * W;
    localparam int unsigned NROWS = W + 1;

    logic [W:0][PW-1:0]       rows;
    logic [NROWS-1:0][PW-1:0] acc;
    logic [PW-1:0]            sum;

    bw_pp_array #(.W(W)) u_pp (
        .a    (op_a),
        .b    (op_b),
        .rows (rows)
    );

    assign acc[0] = rows[0];

    for (genvar k = 1; k < NROWS; k++) begin : g_acc
        bw_rca #(.N(PW)) u_add (
            .x (acc[k - 1]),
            .y (rows[k]),
            .s (acc[k])
        );
    end

    assign sum = acc[NROWS - 1];

    // Checker reference: sign-extended behavioural product (assertions only).
    logic [PW-1:0] chk_ref;
    always_comb chk_ref = PW'($signed({{W{op_a[W-1]}}, op_a}) * $signed({{W{op_b[W-1]}}, op_b}));

    if (OUT_REG) begin : g_reg
        // Output register with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) prod <= '0;
            else        prod <= sum;
        end

        // R6 / R1: registered output equals the exact product one cycle later.
        a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> prod == $past(chk_ref));
        // R7: a low reset at an edge leaves zero on the output.
        a_r7_reset_clear: assert property (@(posedge clk)
            !rst_n |=> prod == '0);
        // R4: zero operand gives zero product.
        a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(op_a == '0 || op_b == '0) |-> prod == '0);
        // R5: sign of a product of nonzero operands.
        a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(op_a != '0 && op_b != '0)
            |-> prod[PW-1] == $past(op_a[W-1] ^ op_b[W-1]));
    end else begin : g_comb
        assign prod = sum;

        // R8 / R1: combinational output equals the exact product.
        a_r8_comb_exact: assert property (@(posedge clk) disable iff (!rst_n)
            prod == chk_ref);
        // R4: zero operand gives zero product.
        a_r4_zero_c: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a == '0 || op_b == '0) |-> prod == '0);
        // R5: sign of a product of nonzero operands.
        a_r5_sign_c: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a != '0 && op_b != '0) |-> prod[PW-1] == (op_a[W-1] ^ op_b[W-1]));
    end

    // R9: the correction row carries ones at bits W and 2W-1 only.
    a_r9_corr_row: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rows[W]) == 2 && rows[W][W] && rows[W][PW-1]);
endmodule

// File: tb/tb_bw_mult.sv
// Bench: table of operand pairs walked by one loop, then directed corner,
// latency, reset and pseudo-random tests on a registered and a combinational copy.
module tb_bw_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] prod_r;
    logic [31:0] prod_c;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    bw_mult #(.W(16), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod_r));
    bw_mult #(.W(16), .OUT_REG(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod_c));

    localparam int NV = 14;
    localparam logic [NV-1:0][31:0] VEC = {
        {16'h0003, 16'h0005}, {16'hFFFD, 16'h0005}, {16'h0003, 16'hFFFB},
        {16'hFFFD, 16'hFFFB}, {16'h0001, 16'hFFFF}, {16'hFFFF, 16'hFFFF},
        {16'h4000, 16'h0002}, {16'h0100, 16'h8001}, {16'h7FFF, 16'h7FFF},
        {16'h1234, 16'hABCD}, {16'h8001, 16'h8001}, {16'h5555, 16'hAAAA},
        {16'h0040, 16'hFF80}, {16'hC000, 16'hC000}
    };

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        return 32'($signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b}));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h)", req, act, exp, op_a, op_b);
        end
    endtask

    // Drive at negedge, pass one posedge, sample at next negedge.
    task automatic apply(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        // R7: reset clears the register despite nonzero operands.
        op_a = 16'h1234;
        op_b = 16'h0101;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7", prod_r, 32'h0);
        check("R8", prod_c, ref_mul(16'h1234, 16'h0101));
        rst_n = 1'b1;

        // R1 / R6 / R8: table walk.
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][31:16], VEC[v][15:0]);
            check("R1", prod_r, ref_mul(VEC[v][31:16], VEC[v][15:0]));
            check("R8", prod_c, ref_mul(VEC[v][31:16], VEC[v][15:0]));
        end

        // R2: most negative squared.
        apply(16'h8000, 16'h8000);
        check("R2", prod_r, 32'h4000_0000);
        check("R2", prod_c, 32'h4000_0000);
        // R3: extremes in both orders.
        apply(16'h8000, 16'h7FFF);
        check("R3", prod_r, 32'hC000_8000);
        apply(16'h7FFF, 16'h8000);
        check("R3", prod_r, 32'hC000_8000);
        check("R3", prod_c, 32'hC000_8000);
        // R4: zero operand.
        apply(16'h0000, 16'h8000);
        check("R4", prod_r, 32'h0);
        apply(16'hFFFF, 16'h0000);
        check("R4", prod_r, 32'h0);
        check("R4", prod_c, 32'h0);
        // R9: correction ones and discarded top carry (-1 x -1 = 1).
        apply(16'hFFFF, 16'hFFFF);
        check("R9", prod_r, 32'h0000_0001);

        // R6: new operands visible combinationally, register holds old value.
        apply(16'h0002, 16'h0003);
        @(negedge clk);
        op_a = 16'h0007;
        op_b = 16'h0009;
        #1;
        check("R6", prod_r, 32'd6);
        check("R8", prod_c, 32'd63);
        @(posedge clk);
        #1;
        check("R6", prod_r, 32'd63);

        // R7: reset asserted mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        op_a = 16'h7FFF;
        op_b = 16'h7FFF;
        @(posedge clk);
        @(negedge clk);
        check("R7", prod_r, 32'h0);
        check("R8", prod_c, 32'h3FFF_0001);
        rst_n = 1'b1;

        // R1 / R5: pseudo-random sweep.
        lfsr = 32'hACE1_1357;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[31:16], lfsr[15:0] ^ lfsr[23:8]);
            check("R1", prod_r, ref_mul(op_a, op_b));
            if (op_a != 0 && op_b != 0)
                check("R5", {31'b0, prod_r[31]}, {31'b0, op_a[15] ^ op_b[15]});
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule